// File: doc/BRIEF.md
# Four-Stage Escalating Watchdog

This block guards a running system against a stall. Once armed, it counts clock cycles through four stages in sequence. Each stage has its own timeout and its own action code, which is applied when that stage runs out. An action can raise an interrupt, pulse a CPU reset, pulse a core reset or pulse a system reset. Software that is still alive strobes the feed input before the first stage expires, so no action is ever taken. If the feeds stop, the watchdog escalates from stage to stage. After the last stage it waits, idle, for a feed or a reset.

A build parameter decides whether this instance may drive the system-reset output at all. When it may not, a system-reset code acts as no action. A second parameter arms a boot guard: from reset the watchdog runs whatever the arm input says, and it keeps running until the first feed. This way a boot that never completes is still caught.

Top module: `wdog_escalate`

## Requirements
- R1: While `rst` is high and on the first cycle after it, all four action outputs are low and the watchdog is in stage 0 with a zero count.
- R2: While running, a stage with timeout value L lasts max(L,1) clock cycles. The stages run in the order 0, 1, 2, 3, and each uses its own timeout field: stage k uses bits [k*CNT_W +: CNT_W] of `stage_limit`.
- R3: When a stage expires, its 3-bit action code from `stage_action[k*3 +: 3]` is applied on the next clock edge. The codes are 0 = none, 1 = interrupt, 2 = CPU reset, 3 = core reset and 4 = system reset. Codes 5 to 7 act as none.
- R4: Code 4 drives `sys_rst` only when the parameter ALLOW_SYS is 1. With ALLOW_SYS = 0, `sys_rst` never rises and code 4 acts as none.
- R5: After stage 3 expires, the watchdog counts no further and takes no further action until a feed or a reset.
- R6: A `feed` strobe returns the watchdog to stage 0 with a zero count. A feed in the same cycle as an expiry wins, and that expiry takes no action.
- R7: Each reset output is a pulse of exactly PULSE_LEN (default 8) cycles. A new expiry with the same action during a pulse restarts the pulse at full length.
- R8: `irq` is a level. Once set, it stays high until an `irq_clr` strobe arrives. If a set and a clear fall in the same cycle, the set wins.
- R9: While `arm` is low and the boot guard is released, the stage and count are held at zero and no action starts. Pulses already running still complete.
- R10: With BOOT_GUARD = 1, the watchdog runs from reset regardless of `arm`, until the first `feed` releases the guard. With BOOT_GUARD = 0, it runs only while `arm` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Run enable; low disables and clears the watchdog |
| feed | input | 1 | Strobe that restarts the watchdog at stage 0 |
| irq_clr | input | 1 | Strobe that clears the interrupt level |
| stage_limit | input | 4*CNT_W | Timeout of each stage, stage 0 in the low field |
| stage_action | input | 12 | 3-bit action code of each stage, stage 0 in the low field |
| irq | output | 1 | Interrupt level |
| cpu_rst | output | 1 | CPU reset pulse |
| core_rst | output | 1 | Core reset pulse |
| sys_rst | output | 1 | System reset pulse |

## Verification
Suppose a stage is entered at clock edge E and its timeout is L. Its action then shows on the outputs just after edge E+max(L,1), and the next stage starts counting at that same edge. A feed, a disable or an interrupt clear takes effect at the first edge that samples it, and a reset pulse falls PULSE_LEN edges after it rose. The bench drives inputs on falling edges and advances a behavioural model on each rising edge, using the same sampled inputs. It compares all four outputs of both instances (ALLOW_SYS/BOOT_GUARD set to 1/1 and 0/0) on every falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ACT_W = 3;
  localparam int NUM_STAGES = 4;
  localparam int NUM_RST = 3;

  typedef enum logic [ACT_W-1:0] {
    ACT_NONE = 3'd0,
    ACT_IRQ  = 3'd1,
    ACT_CPU  = 3'd2,
    ACT_CORE = 3'd3,
    ACT_SYS  = 3'd4
  } wdog_act_e;
endpackage

// File: rtl/wdog_stage_ctr.sv
module wdog_stage_ctr #(
  parameter int CNT_W      = 16,
  parameter int NSTG       = 4,
  parameter bit BOOT_GUARD = 1'b1,
  localparam int SEL_W     = (NSTG > 1) ? $clog2(NSTG) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  arm_i,
  input  logic                  feed_i,
  input  logic [NSTG*CNT_W-1:0] limits_i,
  output logic                  fire_o,
  output logic [SEL_W-1:0]      fire_idx_o,
  output logic [SEL_W:0]        stage_q,
  output logic [CNT_W-1:0]      cnt_q,
  output logic                  guard_q
);
  localparam logic [SEL_W:0] DONE_ST = (SEL_W+1)'(NSTG);

  logic [CNT_W-1:0] lim_arr [NSTG];
  logic [CNT_W-1:0] cur_lim;
  logic [CNT_W-1:0] lim_m1;
  logic [SEL_W-1:0] idx;
  logic             running;
  logic             active;
  logic             expire;

  for (genvar g = 0; g < NSTG; g++) begin : g_lim
    assign lim_arr[g] = limits_i[g*CNT_W +: CNT_W];
  end

  assign idx     = stage_q[SEL_W-1:0];
  assign cur_lim = lim_arr[idx];
  assign lim_m1  = (cur_lim == '0) ? '0 : cur_lim - 1'b1;
  assign running = arm_i | guard_q;
  assign active  = running && !feed_i && (stage_q != DONE_ST);
  assign expire  = active && (cnt_q >= lim_m1);

  assign fire_o     = expire;
  assign fire_idx_o = idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      cnt_q   <= '0;
      guard_q <= BOOT_GUARD;
    end else begin
      if (feed_i) guard_q <= 1'b0;
      if (!running || feed_i) begin
        stage_q <= '0;
        cnt_q   <= '0;
      end else if (expire) begin
        stage_q <= stage_q + 1'b1;
        cnt_q   <= '0;
      end else if (stage_q != DONE_ST) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdog_act_map.sv
module wdog_act_map
  import wdog_pkg::*;
#(
  parameter bit ALLOW_SYS = 1'b1
) (
  input  logic               fire_i,
  input  logic [ACT_W-1:0]   act_i,
  output logic               irq_set_o,
  output logic [NUM_RST-1:0] rst_trig_o
);
  always_comb begin
    irq_set_o  = 1'b0;
    rst_trig_o = '0;
    if (fire_i) begin
      unique case (act_i)
        ACT_IRQ:  irq_set_o     = 1'b1;
        ACT_CPU:  rst_trig_o[0] = 1'b1;
        ACT_CORE: rst_trig_o[1] = 1'b1;
        ACT_SYS:  rst_trig_o[2] = ALLOW_SYS;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int LEN = 8,
  localparam int PW = $clog2(LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  output logic pulse_o
);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      pulse_o <= 1'b0;
    end else if (trig_i) begin
      left_q  <= PW'(LEN - 1);
      pulse_o <= 1'b1;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end else begin
      pulse_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate
  import wdog_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int PULSE_LEN  = 8,
  parameter bit ALLOW_SYS  = 1'b1,
  parameter bit BOOT_GUARD = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        arm,
  input  logic                        feed,
  input  logic                        irq_clr,
  input  logic [NUM_STAGES*CNT_W-1:0] stage_limit,
  input  logic [NUM_STAGES*ACT_W-1:0] stage_action,
  output logic                        irq,
  output logic                        cpu_rst,
  output logic                        core_rst,
  output logic                        sys_rst
);
  localparam int SEL_W = $clog2(NUM_STAGES);

  logic               fire;
  logic [SEL_W-1:0]   fire_idx;
  logic [SEL_W:0]     stage_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               guard_q;
  logic [ACT_W-1:0]   act_arr [NUM_STAGES];
  logic [ACT_W-1:0]   act_sel;
  logic               irq_set;
  logic [NUM_RST-1:0] rst_trig;
  logic [NUM_RST-1:0] rst_out;

  wdog_stage_ctr #(
    .CNT_W(CNT_W), .NSTG(NUM_STAGES), .BOOT_GUARD(BOOT_GUARD)
  ) u_ctr (
    .clk(clk), .rst(rst), .arm_i(arm), .feed_i(feed),
    .limits_i(stage_limit), .fire_o(fire), .fire_idx_o(fire_idx),
    .stage_q(stage_q), .cnt_q(cnt_q), .guard_q(guard_q)
  );

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_act
    assign act_arr[g] = stage_action[g*ACT_W +: ACT_W];
  end
  assign act_sel = act_arr[fire_idx];

  wdog_act_map #(.ALLOW_SYS(ALLOW_SYS)) u_map (
    .fire_i(fire), .act_i(act_sel),
    .irq_set_o(irq_set), .rst_trig_o(rst_trig)
  );

  for (genvar r = 0; r < NUM_RST; r++) begin : g_pulse
    wdog_pulse #(.LEN(PULSE_LEN)) u_pulse (
      .clk(clk), .rst(rst), .trig_i(rst_trig[r]), .pulse_o(rst_out[r])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)          irq <= 1'b0;
    else if (irq_set) irq <= 1'b1;
    else if (irq_clr) irq <= 1'b0;
  end

  assign cpu_rst  = rst_out[0];
  assign core_rst = rst_out[1];
  assign sys_rst  = rst_out[2];
endmodule

module wdog_escalate_chk #(
  parameter int CNT_W     = 16,
  parameter int SEL_W     = 2,
  parameter int PULSE_LEN = 8,
  parameter bit ALLOW_SYS = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             arm,
  input logic             feed,
  input logic             irq_clr,
  input logic             irq,
  input logic             cpu_rst,
  input logic             core_rst,
  input logic             sys_rst,
  input logic [SEL_W:0]   stage_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             guard_q
);
  logic [2:0] outs;
  logic [7:0] hi_len [3];
  assign outs = {sys_rst, core_rst, cpu_rst};

  for (genvar r = 0; r < 3; r++) begin : g_len
    always_ff @(posedge clk) begin
      if (rst)                hi_len[r] <= '0;
      else if (!outs[r])      hi_len[r] <= '0;
      else if (hi_len[r] != 8'hff) hi_len[r] <= hi_len[r] + 1'b1;
    end
    assert_pulse_min_R7: assert property (@(posedge clk) disable iff (rst)
      $fell(outs[r]) |-> (hi_len[r] >= 8'(PULSE_LEN)));
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!irq && !cpu_rst && !core_rst && !sys_rst && stage_q == '0 && cnt_q == '0));

  assert_feed_restart_R6: assert property (@(posedge clk) disable iff (rst)
    feed |=> (stage_q == '0 && cnt_q == '0));

  assert_irq_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);

  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (!arm && !guard_q) |=> (!$rose(irq) && !$rose(cpu_rst) && !$rose(core_rst)
                            && !$rose(sys_rst) && stage_q == '0 && cnt_q == '0));

  always_ff @(posedge clk) begin
    if (!rst && !ALLOW_SYS) assert_no_sys_R4: assert (!sys_rst);
  end
endmodule

bind wdog_escalate wdog_escalate_chk #(
  .CNT_W(CNT_W), .SEL_W(SEL_W), .PULSE_LEN(PULSE_LEN), .ALLOW_SYS(ALLOW_SYS)
) u_chk (
  .clk(clk), .rst(rst), .arm(arm), .feed(feed), .irq_clr(irq_clr),
  .irq(irq), .cpu_rst(cpu_rst), .core_rst(core_rst), .sys_rst(sys_rst),
  .stage_q(stage_q), .cnt_q(cnt_q), .guard_q(guard_q)
);

// File: tb/sim_wdog_escalate.sv
`timescale 1ns/1ps
module sim_wdog_escalate;
  localparam int CW = 16;
  localparam int PL = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arm = 1'b0, feed = 1'b0, irq_clr = 1'b0;
  logic [4*CW-1:0] lims = '0;
  logic [11:0] acts = '0;
  logic [3:0] o0, o1;

  always #10 clk = ~clk;

  wdog_escalate #(.CNT_W(CW), .PULSE_LEN(PL), .ALLOW_SYS(1'b1), .BOOT_GUARD(1'b1)) u0 (
    .clk(clk), .rst(rst), .arm(arm), .feed(feed), .irq_clr(irq_clr),
    .stage_limit(lims), .stage_action(acts),
    .irq(o0[0]), .cpu_rst(o0[1]), .core_rst(o0[2]), .sys_rst(o0[3]));

  wdog_escalate #(.CNT_W(CW), .PULSE_LEN(PL), .ALLOW_SYS(1'b0), .BOOT_GUARD(1'b0)) u1 (
    .clk(clk), .rst(rst), .arm(arm), .feed(feed), .irq_clr(irq_clr),
    .stage_limit(lims), .stage_action(acts),
    .irq(o1[0]), .cpu_rst(o1[1]), .core_rst(o1[2]), .sys_rst(o1[3]));

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  string cur_req = "R1";

  // behavioural reference model, one entry per instance
  bit allow_m [2] = '{1'b1, 1'b0};
  bit guard_init [2] = '{1'b1, 1'b0};
  int m_stage [2], m_cnt [2];
  bit m_guard [2], m_irq [2];
  int m_p [2][3];

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (rst) begin
        m_stage[i] = 0; m_cnt[i] = 0; m_guard[i] = guard_init[i]; m_irq[i] = 0;
        for (int j = 0; j < 3; j++) m_p[i][j] = 0;
      end else begin
        bit run, fire;
        int act, lim;
        run = arm || m_guard[i];
        fire = 0; act = 0;
        if (feed) m_guard[i] = 0;
        if (!run || feed) begin
          m_stage[i] = 0; m_cnt[i] = 0;
        end else if (m_stage[i] < 4) begin
          lim = int'(lims[m_stage[i]*CW +: CW]);
          if (lim == 0) lim = 1;
          if (m_cnt[i] + 1 >= lim) begin
            fire = 1; act = int'(acts[m_stage[i]*3 +: 3]);
            m_stage[i]++; m_cnt[i] = 0;
          end else m_cnt[i]++;
        end
        if (act == 4 && !allow_m[i]) act = 0;
        if (act > 4) act = 0;
        if (fire && act == 1) m_irq[i] = 1;
        else if (irq_clr) m_irq[i] = 0;
        for (int j = 0; j < 3; j++) begin
          if (fire && act == j + 2) m_p[i][j] = PL;
          else if (m_p[i][j] > 0) m_p[i][j]--;
        end
      end
    end
  end

  function automatic logic [3:0] exp_out(int i);
    return {m_p[i][2] > 0, m_p[i][1] > 0, m_p[i][0] > 0, m_irq[i]};
  endfunction

  always @(negedge clk) begin
    if (!finished) begin
      n_chk += 2;
      if (o0 !== exp_out(0)) begin
        n_fail++;
        $display("FAIL %s u0 t=%0t actual=%b expected=%b (sys,core,cpu,irq)", cur_req, $time, o0, exp_out(0));
      end
      if (o1 !== exp_out(1)) begin
        n_fail++;
        $display("FAIL %s u1 t=%0t actual=%b expected=%b (sys,core,cpu,irq)", cur_req, $time, o1, exp_out(1));
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(int l0, int l1, int l2, int l3, int a0, int a1, int a2, int a3);
    lims = {CW'(l3), CW'(l2), CW'(l1), CW'(l0)};
    acts = {3'(a3), 3'(a2), 3'(a1), 3'(a0)};
  endtask

  task automatic do_feed();
    feed = 1'b1; step(1); feed = 1'b0;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1; n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    cfg(5, 3, 4, 2, 1, 2, 3, 4);
    step(3);
    // R1: reset state checked explicitly as well as by the model
    n_chk++;
    if (o0 !== 4'b0 || o1 !== 4'b0) begin
      n_fail++; $display("FAIL R1 actual=%b/%b expected=0000/0000", o0, o1);
    end
    rst = 1'b0;
    // R10 R2 R3 R4 R5 R7: u0 runs on boot guard and escalates, u1 stays idle
    cur_req = "R10/R2/R3/R4/R5/R7";
    step(40);
    // R8: clear interrupt
    cur_req = "R8";
    irq_clr = 1'b1; step(1); irq_clr = 1'b0; step(3);
    // R10 release, then R9: disabled, nothing happens
    cur_req = "R10/R9";
    do_feed();
    step(30);
    // R7: retrigger of the same reset during a pulse
    cur_req = "R7";
    arm = 1'b1; do_feed();
    cfg(3, 3, 3, 3, 2, 2, 0, 1);
    step(30);
    // R6: regular feeds, including on the expiry cycle, keep it quiet
    cur_req = "R6";
    cfg(2, 2, 2, 2, 1, 2, 3, 4);
    do_feed();
    for (int k = 0; k < 10; k++) begin step(1); do_feed(); end
    step(20);
    // R3: codes 5..7 and 0 do nothing
    cur_req = "R3";
    irq_clr = 1'b1; step(1); irq_clr = 1'b0;
    cfg(2, 2, 2, 2, 5, 6, 7, 0);
    do_feed(); step(20);
    // R2: zero timeout counts as one cycle
    cur_req = "R2";
    cfg(0, 1, 0, 2, 2, 3, 4, 1);
    do_feed(); step(20);
    // R8: set and clear in the same cycle, set wins
    cur_req = "R8";
    cfg(3, 40, 40, 40, 1, 0, 0, 0);
    irq_clr = 1'b1; do_feed(); step(6); irq_clr = 1'b0; step(3);
    irq_clr = 1'b1; step(1); irq_clr = 1'b0;
    // R9: disable in the middle of a stage
    cur_req = "R9";
    cfg(6, 6, 6, 6, 2, 1, 3, 4);
    do_feed(); step(4); arm = 1'b0; step(20);
    arm = 1'b1; step(40);
    // R4: u0 drives system reset, u1 must not
    cur_req = "R4";
    cfg(1, 1, 1, 1, 4, 4, 0, 0);
    do_feed(); step(20);
    // R1: reset during activity
    cur_req = "R1";
    cfg(1, 1, 1, 1, 2, 1, 3, 4);
    do_feed(); step(2); rst = 1'b1; step(2); rst = 1'b0; arm = 1'b0; step(5);
    finished = 1;
    report();
  end
endmodule